// File: doc/BRIEF.md
# UART Interrupt Identification and Request Logic

This block merges the interrupt sources of a serial port into one prioritised identification byte and one active-high interrupt request. The line error flags, the data-ready flag, the receive FIFO fill level and threshold, the character-timeout flag and the modem delta bits all arrive as inputs from the neighbouring logic. The block itself holds the 4-bit interrupt enable register and the transmit-empty pending flag. That flag is raised when the holding register drains and is updated by software register accesses.

The identification byte and the request line are registered. Each one is computed from the inputs sampled at a clock edge and from the enable and pending state as they stand after that edge. The bus decoder passes register accesses in as single-cycle strobes. `ier_wr_i` marks a write to the enable register, `thr_wr_i` a write to the transmit holding register, and `iid_rd_i` a read of the identification byte. A read returns the current `iid_o`.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and at its release, `iid_o` = 0x01, `irq_o` = 0 and `ier_o` = 0.
- R2: A write strobe stores `ier_wdata_i[3:0]` in the enable register, and `ier_o` shows it after the next edge. Bits 7:4 are dropped. Bit 0 enables receive data and character timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R3: `iid_o[3:0]` carries the highest-priority active enabled source. In priority order the codes are: line status 0x6, character timeout 0xC, receive data 0x4, transmit empty 0x2, modem change 0x0. The code 0x1 means nothing is pending.
- R4: A line status interrupt needs enable bit 2 and at least one of the four `line_err_i` bits (overrun, parity, framing, break).
- R5: A pending character timeout is reported only while enable bit 0 is set.
- R6: Receive data needs enable bit 0 and `data_ready_i`. When `fifo_en_i` is set it also needs `rx_count_i >= rx_trig_i`.
- R7: `iid_o[7:6]` is 2'b11 when `fifo_en_i` was set at the sampling edge and 2'b00 otherwise. `iid_o[5:4]` is always 0.
- R8: `irq_o` is high exactly when `iid_o[3:0]` is not 0x1.
- R9: A `tx_drained_i` pulse sets the transmit-empty pending flag. A holding-register write clears it. The source counts only while enable bit 1 is set.
- R10: A read of the identification byte while `iid_o[3:0]` = 0x2 clears the pending flag. A read while any other code is shown leaves the flag unchanged.
- R11: An enable write that changes bit 1 sets the pending flag to (new bit 1 AND `thr_empty_i`). An enable write that leaves bit 1 unchanged does not touch the flag. In one cycle the updates apply in this order, with the later one winning: drain set, read clear, holding write clear, enable-write rule.
- R12: `iid_o` and `irq_o` change only at a clock edge and reflect the inputs sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ier_wr_i | input | 1 | Write strobe for the enable register |
| ier_wdata_i | input | 8 | Enable register write data |
| thr_wr_i | input | 1 | Write strobe for the transmit holding register |
| iid_rd_i | input | 1 | Read strobe for the identification byte |
| tx_drained_i | input | 1 | Pulse when the holding register becomes empty |
| thr_empty_i | input | 1 | Holding register currently empty |
| line_err_i | input | 4 | Overrun, parity, framing, break flags |
| data_ready_i | input | 1 | Receive data ready |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill level |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| timeout_pend_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 4 | Enable register contents |
| iid_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every result is due exactly one edge after its stimulus. This holds for source inputs, strobes and enable writes alike: a stimulus driven before edge k shows on `ier_o`, `iid_o` and `irq_o` after edge k, and nowhere earlier. The bench drives inputs on the falling edge and steps its reference model at the rising edge. It compares all three outputs at the following falling edge, so each comparison falls in the one cycle where the new value is due. One directed check also samples just before the edge to confirm that the output has not yet moved. A mix of directed sequences (priority ladder, threshold boundary, pending-flag re-arm and precedence) and a long random run share the same comparison.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THR     = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_code_e;

  localparam int ENB_RX    = 0;
  localparam int ENB_THR   = 1;
  localparam int ENB_LINE  = 2;
  localparam int ENB_MODEM = 3;
  localparam int ENB_W     = 4;

  // Source slots, index 0 is the highest priority.
  localparam int NUM_SRC = 5;

  function automatic iid_code_e src_code(input int idx);
    case (idx)
      0:       return IID_LINE;
      1:       return IID_TIMEOUT;
      2:       return IID_RXDATA;
      3:       return IID_THR;
      default: return IID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ier_wr_i,
  input  logic [7:0]        ier_wdata_i,
  input  logic              thr_wr_i,
  input  logic              ack_thr_i,
  input  logic              tx_drained_i,
  input  logic              thr_empty_i,
  output logic [ENB_W-1:0]  ier_q_o,
  output logic [ENB_W-1:0]  ier_next_o,
  output logic              pend_next_o
);

  logic [ENB_W-1:0] ier_q, ier_d;
  logic             pend_q, pend_d;
  logic             pend_en;
  logic [3:0]       unused_hi;

  assign unused_hi = ier_wdata_i[7:4];

  // Later statements take precedence within a cycle.
  always_comb begin
    ier_d  = ier_q;
    pend_d = pend_q;
    if (tx_drained_i) pend_d = 1'b1;
    if (ack_thr_i)    pend_d = 1'b0;
    if (thr_wr_i)     pend_d = 1'b0;
    if (ier_wr_i) begin
      ier_d = ier_wdata_i[ENB_W-1:0];
      if (ier_wdata_i[ENB_THR] != ier_q[ENB_THR])
        pend_d = ier_wdata_i[ENB_THR] & thr_empty_i;
    end
  end

  assign pend_en = tx_drained_i | ack_thr_i | thr_wr_i | ier_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ier_wr_i) ier_q  <= ier_d;
      if (pend_en)  pend_q <= pend_d;
    end
  end

  assign ier_q_o     = ier_q;
  assign ier_next_o  = ier_d;
  assign pend_next_o = pend_d;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [ENB_W-1:0]  ier_i,
  input  logic [3:0]        line_err_i,
  input  logic              timeout_pend_i,
  input  logic              data_ready_i,
  input  logic              fifo_en_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  rx_trig_i,
  input  logic              thr_pend_i,
  input  logic [3:0]        msr_delta_i,
  output iid_code_e         code_o
);

  logic [NUM_SRC-1:0] req;
  logic               level_ok;

  assign level_ok = !fifo_en_i || (rx_count_i >= rx_trig_i);

  always_comb begin
    req[0] = ier_i[ENB_LINE]  && (|line_err_i);
    req[1] = ier_i[ENB_RX]    && timeout_pend_i;
    req[2] = ier_i[ENB_RX]    && data_ready_i && level_ok;
    req[3] = ier_i[ENB_THR]   && thr_pend_i;
    req[4] = ier_i[ENB_MODEM] && (|msr_delta_i);
  end

  // Scan from lowest to highest priority so the highest active slot wins.
  always_comb begin
    code_o = IID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code_o = src_code(i);
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ier_wr_i,
  input  logic [7:0]        ier_wdata_i,
  input  logic              thr_wr_i,
  input  logic              iid_rd_i,
  input  logic              tx_drained_i,
  input  logic              thr_empty_i,
  input  logic [3:0]        line_err_i,
  input  logic              data_ready_i,
  input  logic              fifo_en_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  rx_trig_i,
  input  logic              timeout_pend_i,
  input  logic [3:0]        msr_delta_i,
  output logic [ENB_W-1:0]  ier_o,
  output logic [7:0]        iid_o,
  output logic              irq_o
);

  logic [7:0]       iid_q, iid_d;
  logic             irq_q, irq_d;
  logic             ack_thr;
  logic [ENB_W-1:0] ier_next;
  logic             pend_next;
  iid_code_e        code;

  assign ack_thr = iid_rd_i && (iid_q[3:0] == IID_THR);

  uart_irq_enable_reg u_enable (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ier_wr_i     (ier_wr_i),
    .ier_wdata_i  (ier_wdata_i),
    .thr_wr_i     (thr_wr_i),
    .ack_thr_i    (ack_thr),
    .tx_drained_i (tx_drained_i),
    .thr_empty_i  (thr_empty_i),
    .ier_q_o      (ier_o),
    .ier_next_o   (ier_next),
    .pend_next_o  (pend_next)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier_i          (ier_next),
    .line_err_i     (line_err_i),
    .timeout_pend_i (timeout_pend_i),
    .data_ready_i   (data_ready_i),
    .fifo_en_i      (fifo_en_i),
    .rx_count_i     (rx_count_i),
    .rx_trig_i      (rx_trig_i),
    .thr_pend_i     (pend_next),
    .msr_delta_i    (msr_delta_i),
    .code_o         (code)
  );

  always_comb begin
    iid_d = {{2{fifo_en_i}}, 2'b00, code};
    irq_d = (code != IID_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iid_q <= {4'h0, IID_NONE};
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= irq_d;
    end
  end

  assign iid_o = iid_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/uart_irq_ident_sva.sv
module uart_irq_ident_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ier_wr_i,
  input logic [7:0] ier_wdata_i,
  input logic       thr_wr_i,
  input logic       iid_rd_i,
  input logic [3:0] line_err_i,
  input logic       fifo_en_i,
  input logic [3:0] ier_o,
  input logic [7:0] iid_o,
  input logic       irq_o
);

  assert_ier_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr_i |=> ier_o == $past(ier_wdata_i[3:0]));

  assert_line_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[2] && (|line_err_i) && !ier_wr_i) |=> iid_o[3:0] == 4'h6);

  assert_rx_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ier_o[0] && !ier_wr_i) |=> (iid_o[3:0] != 4'hC && iid_o[3:0] != 4'h4));

  assert_fifo_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i |=> iid_o[7:4] == 4'hC);

  assert_fifo_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> iid_o[7:4] == 4'h0);

  assert_irq_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iid_o[3:0] != 4'h1));

  assert_thr_write_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !ier_wr_i) |=> iid_o[3:0] != 4'h2);

  assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_rd_i && iid_o[3:0] == 4'h2 && !ier_wr_i) |=> iid_o[3:0] != 4'h2);

endmodule

bind uart_irq_ident uart_irq_ident_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ier_wr_i    (ier_wr_i),
  .ier_wdata_i (ier_wdata_i),
  .thr_wr_i    (thr_wr_i),
  .iid_rd_i    (iid_rd_i),
  .line_err_i  (line_err_i),
  .fifo_en_i   (fifo_en_i),
  .ier_o       (ier_o),
  .iid_o       (iid_o),
  .irq_o       (irq_o)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 1'b0;
  logic [7:0]    ier_wdata = '0;
  logic          thr_wr = 1'b0;
  logic          iid_rd = 1'b0;
  logic          drained = 1'b0;
  logic          thr_empty = 1'b0;
  logic [3:0]    line_err = '0;
  logic          dr = 1'b0;
  logic          fifo_en = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [CW-1:0] trig = '0;
  logic          tmo = 1'b0;
  logic [3:0]    msr = '0;
  logic [3:0]    ier_o;
  logic [7:0]    iid_o;
  logic          irq_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  // Reference model state
  int  m_ier  = 0;
  int  m_pend = 0;
  int  m_iid  = 1;
  int  m_irq  = 0;

  always #5 clk = ~clk;

  uart_irq_ident uut (
    .clk_i (clk), .rst_ni (rst_n),
    .ier_wr_i (ier_wr), .ier_wdata_i (ier_wdata),
    .thr_wr_i (thr_wr), .iid_rd_i (iid_rd),
    .tx_drained_i (drained), .thr_empty_i (thr_empty),
    .line_err_i (line_err), .data_ready_i (dr),
    .fifo_en_i (fifo_en), .rx_count_i (cnt), .rx_trig_i (trig),
    .timeout_pend_i (tmo), .msr_delta_i (msr),
    .ier_o (ier_o), .iid_o (iid_o), .irq_o (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_update();
    int code;
    if (drained) m_pend = 1;
    if (iid_rd && (m_iid % 16) == 2) m_pend = 0;
    if (thr_wr) m_pend = 0;
    if (ier_wr) begin
      if (int'(ier_wdata[1]) != ((m_ier / 2) % 2)) m_pend = (ier_wdata[1] && thr_empty) ? 1 : 0;
      m_ier = int'(ier_wdata) % 16;
    end
    if ((m_ier & 4) != 0 && line_err != 0)                      code = 6;
    else if ((m_ier & 1) != 0 && tmo)                           code = 12;
    else if ((m_ier & 1) != 0 && dr && (!fifo_en || cnt >= trig)) code = 4;
    else if ((m_ier & 2) != 0 && m_pend == 1)                   code = 2;
    else if ((m_ier & 8) != 0 && msr != 0)                      code = 0;
    else                                                        code = 1;
    m_iid = code + (fifo_en ? 192 : 0);
    m_irq = (code != 1) ? 1 : 0;
  endtask

  // One clock: model steps at the edge, outputs compared at the next falling edge.
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R3 R12 model iid", iid_o, m_iid);
    chk("R8 model irq", irq_o, m_irq);
    chk("R2 model ier", ier_o, m_ier);
    ier_wr = 0; thr_wr = 0; iid_rd = 0; drained = 0;
  endtask

  task automatic set_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset iid", iid_o, 8'h01);
    chk("R1 reset irq", irq_o, 1'b0);
    chk("R1 reset ier", ier_o, 4'h0);
    rst_n = 1;
    step();
    chk("R1 after release iid", iid_o, 8'h01);

    set_ier(8'hF5);
    chk("R2 upper bits dropped", ier_o, 4'h5);

    fifo_en = 1; line_err = 4'b0010; step();
    chk("R4 R7 line status with fifo", iid_o, 8'hC6);
    chk("R8 irq raised", irq_o, 1'b1);

    line_err = 0; tmo = 1; step();
    chk("R5 timeout reported", iid_o, 8'hCC);
    set_ier(8'h04);
    chk("R5 timeout gated by rx enable", iid_o, 8'hC1);
    chk("R8 irq low", irq_o, 1'b0);

    tmo = 0; dr = 1; cnt = 3; trig = 4; set_ier(8'h01);
    chk("R6 below trigger", iid_o, 8'hC1);
    cnt = 4; step();
    chk("R6 at trigger", iid_o, 8'hC4);
    fifo_en = 0; cnt = 0; step();
    chk("R6 R7 no fifo data ready", iid_o, 8'h04);

    dr = 0; thr_empty = 1; set_ier(8'h02);
    chk("R11 enable arms pending", iid_o, 8'h02);
    iid_rd = 1; step();
    chk("R10 read acknowledges", iid_o, 8'h01);
    set_ier(8'h02);
    chk("R11 unchanged bit keeps flag", iid_o, 8'h01);
    set_ier(8'h00);
    set_ier(8'h02);
    chk("R11 re-arm after toggle", iid_o, 8'h02);
    thr_wr = 1; step();
    chk("R9 holding write clears", iid_o, 8'h01);
    drained = 1; step();
    chk("R9 drain sets pending", iid_o, 8'h02);

    dr = 1; tmo = 1; line_err = 4'b0001; msr = 4'b0001; set_ier(8'h0F);
    chk("R3 line first", iid_o, 8'h06);
    line_err = 0; step();
    chk("R3 timeout second", iid_o, 8'h0C);
    tmo = 0; step();
    chk("R3 rx data third", iid_o, 8'h04);
    iid_rd = 1; step();
    dr = 0; step();
    chk("R10 read of other code keeps flag", iid_o, 8'h02);
    iid_rd = 1; step();
    chk("R3 R10 modem last", iid_o, 8'h00);
    chk("R8 modem raises irq", irq_o, 1'b1);
    msr = 0; step();

    set_ier(8'h0D);
    chk("R11 disabling drops flag", iid_o, 8'h01);
    ier_wr = 1; ier_wdata = 8'h0F; thr_wr = 1; step();
    chk("R11 enable rule beats holding write", iid_o, 8'h02);

    line_err = 4'b1000;
    #1;
    chk("R12 no change before edge", iid_o, 8'h02);
    step();
    chk("R12 change after one edge", iid_o, 8'h06);
    line_err = 0; step();

    for (int i = 0; i < 4000; i++) begin
      ier_wr    = ($urandom % 8) == 0;
      ier_wdata = 8'($urandom);
      thr_wr    = ($urandom % 8) == 0;
      iid_rd    = ($urandom % 4) == 0;
      drained   = ($urandom % 6) == 0;
      thr_empty = 1'($urandom);
      line_err  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      tmo       = ($urandom % 8) == 0;
      dr        = 1'($urandom);
      if (($urandom % 16) == 0) fifo_en = ~fifo_en;
      cnt       = CW'($urandom % 17);
      case ($urandom % 4)
        0: trig = 1; 1: trig = 4; 2: trig = 8; default: trig = 14;
      endcase
      msr       = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule